// File: doc/BRIEF.md
# Boot-Flash Mapped Read Arbiter

This block decides which of two users drives a single serial flash bus. By default a memory-mapped boot read engine owns the bus. It turns each read request that falls inside a 32 MiB window into a flash read frame: chip select goes low, the command byte 0x03 goes out, then a 24-bit address, and then the requested number of data bytes are shifted in. A register-driven queued SPI master can take the bus instead. Software moves ownership through a one-bit mode register, and a busy bit shows when a mapped read is still in flight.

Handing the bus to the queued master is refused while the mapped engine is busy. Every change of owner passes through a fixed settle gap. During that gap neither side selects the flash. Requests enter on a valid/ready stream, and bytes leave on a second valid/ready stream. A request is taken only when the mapped path owns the bus, the engine is idle and no response beat is still waiting. A response beat holds its data until it is accepted. While a beat is stalled, the serial clock pauses at the byte boundary, so back-pressure never loses or corrupts data. The serial address field carries the low 24 bits of the offset. The window check uses the full offset.

Top module: `flash_boot_arbiter`

## Requirements
- R1: After reset the mode bit reads 0 (mapped path owns the bus) and the busy bit reads 0. `qm_grant` is 0, `spi_cs_n` is 1, `rd_rsp_valid` is 0 and `rd_req_ready` is 1.
- R2: Register address 0 holds the mode bit in bit 0, where 1 means the queued master and 0 means the mapped path. Register address 1 returns the busy bit in bit 0. A write of `reg_wr_bit` to address 0 updates the mode bit, and the new value can be read back.
- R3: The busy bit is 1 exactly while the mapped engine holds chip select low. This runs from the cycle after a request is accepted until the cycle after the final byte is loaded into the response register.
- R4: A write of 1 to the mode bit while busy is 1 is ignored. The mode bit stays 0, `qm_grant` stays 0 and the mapped read finishes with correct data.
- R5: After each mode change there are exactly SETTLE cycles (default 4) in which `qm_grant` is 0, `rd_req_ready` is 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R6: While `qm_grant` is 1, `spi_sck`, `spi_cs_n` and `spi_mosi` follow `qm_sck`, `qm_cs_n` and `qm_mosi`, and `qm_miso` follows `spi_miso`.
- R7: While the mapped path does not own the bus, `rd_req_ready` is 0. A request held valid across that time is served unchanged once ownership returns.
- R8: A mapped read drives chip select low and sends 0x03, then offset bits 23..0. Both go MSB first in SPI mode 0: the clock idles low, MOSI changes while the clock is low, and MISO is sampled on the rising edge.
- R9: `rd_req_len` holds the byte count minus one. The response gives that many plus one bytes, each assembled MSB first from MISO, and `rd_rsp_last` is set on the final beat only.
- R10: A request with offset + byte count greater than 2^25 gets a single beat with `rd_rsp_err` and `rd_rsp_last` set, and chip select never goes low. A request ending exactly at 2^25 is served normally.
- R11: While `rd_rsp_valid` is 1 and `rd_rsp_ready` is 0, the data, error and last fields stay unchanged. Once the next byte has been shifted in, the serial clock stays low with chip select held low.
- R12: `rd_req_ready` is 0 while the engine is busy or a response beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = mode, 1 = busy |
| reg_wr_bit | input | 1 | Value written to the mode bit |
| reg_rdata | output | REG_DW | Read data for reg_addr |
| rd_req_valid | input | 1 | Mapped read request valid |
| rd_req_ready | output | 1 | Mapped read request accepted |
| rd_req_off | input | OFF_W | Byte offset into the window |
| rd_req_len | input | LEN_W | Byte count minus one |
| rd_rsp_valid | output | 1 | Response beat valid |
| rd_rsp_ready | input | 1 | Response beat accepted |
| rd_rsp_data | output | 8 | Read byte |
| rd_rsp_err | output | 1 | Window violation |
| rd_rsp_last | output | 1 | Final beat of the request |
| qm_grant | output | 1 | Queued master owns the bus |
| qm_sck | input | 1 | Queued master clock |
| qm_cs_n | input | 1 | Queued master chip select |
| qm_mosi | input | 1 | Queued master data out |
| qm_miso | output | 1 | Flash data to the queued master |
| spi_sck | output | 1 | Flash serial clock |
| spi_cs_n | output | 1 | Flash chip select |
| spi_mosi | output | 1 | Flash data in |
| spi_miso | input | 1 | Flash data out |

## Verification
A wrong owner or settle count shows on the grant and chip-select pins within SETTLE+1 cycles of the mode write. The bench counts the gap exactly in both directions. A fault in the engine's frame shifter corrupts the command or address that the flash model decodes on the first 32 rising edges of the frame. A fault in the byte assembler shows in the first response beat. The busy bit is compared against chip select on every cycle, so a stuck or early busy is reported in the same cycle it differs. A back-pressure fault appears as a clock edge or a changed response field within a few cycles of a stall.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_CMD,
    ENG_DATA,
    ENG_PUSH
  } eng_state_e;

  localparam logic [7:0] READ_CMD = 8'h03;
endpackage

// File: rtl/flash_own_ctrl.sv
module flash_own_ctrl #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_q,
  input  logic set_map,
  output logic mode_q,
  output logic own_q
);
  localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);

  logic [CNT_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      own_q   <= 1'b0;
      gap_cnt <= '0;
    end else begin
      if (set_map)    mode_q <= 1'b0;
      else if (set_q) mode_q <= 1'b1;

      if (mode_q != own_q) begin
        if (gap_cnt == CNT_W'(SETTLE - 1)) begin
          own_q   <= mode_q;
          gap_cnt <= '0;
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
      end else begin
        gap_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/flash_map_engine.sv
module flash_map_engine
  import flash_arb_pkg::*;
#(
  parameter int WIN_BITS = 25,
  parameter int OFF_W    = WIN_BITS + 1,
  parameter int LEN_W    = 6,
  parameter int ADDR_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [OFF_W-1:0] req_off,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             rsp_err,
  output logic             rsp_last,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int FRAME_W = 8 + ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int SUM_W   = OFF_W + 1;
  localparam logic [SUM_W-1:0] WIN_SIZE = SUM_W'(1) << WIN_BITS;

  eng_state_e         st;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;
  logic [LEN_W-1:0]   left;
  logic [7:0]         rx;
  logic [SUM_W-1:0]   end_off;
  logic               over;
  logic               accept;

  assign end_off   = {1'b0, req_off} + SUM_W'(req_len) + SUM_W'(1);
  assign over      = end_off > WIN_SIZE;
  assign req_ready = start_ok && (st == ENG_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign busy      = (st != ENG_IDLE);
  assign mosi      = (st == ENG_CMD) ? frame[FRAME_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ENG_IDLE;
      frame     <= '0;
      bit_cnt   <= '0;
      left      <= '0;
      rx        <= '0;
      sck       <= 1'b0;
      cs_n      <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_last  <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        ENG_IDLE: begin
          if (accept) begin
            if (over) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_last  <= 1'b1;
              rsp_data  <= '0;
            end else begin
              st      <= ENG_CMD;
              cs_n    <= 1'b0;
              frame   <= {READ_CMD, req_off[ADDR_W-1:0]};
              left    <= req_len;
              bit_cnt <= '0;
              sck     <= 1'b0;
            end
          end
        end
        ENG_CMD: begin
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck   <= 1'b0;
            frame <= {frame[FRAME_W-2:0], 1'b0};
            if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
              bit_cnt <= '0;
              st      <= ENG_DATA;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ENG_DATA: begin
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            rx  <= {rx[6:0], miso};
            if (bit_cnt == CNT_W'(7)) begin
              bit_cnt <= '0;
              st      <= ENG_PUSH;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ENG_PUSH: begin
          if (!rsp_valid || rsp_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rx;
            rsp_err   <= 1'b0;
            rsp_last  <= (left == '0);
            if (left == '0) begin
              cs_n <= 1'b1;
              st   <= ENG_IDLE;
            end else begin
              left <= left - 1'b1;
              st   <= ENG_DATA;
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pin_mux.sv
module flash_pin_mux (
  input  logic grant,
  input  logic map_en,
  input  logic eng_sck,
  input  logic eng_cs_n,
  input  logic eng_mosi,
  output logic eng_miso,
  input  logic qm_sck,
  input  logic qm_cs_n,
  input  logic qm_mosi,
  output logic qm_miso,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);
  always_comb begin
    spi_sck  = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    if (grant) begin
      spi_sck  = qm_sck;
      spi_cs_n = qm_cs_n;
      spi_mosi = qm_mosi;
    end else if (map_en) begin
      spi_sck  = eng_sck;
      spi_cs_n = eng_cs_n;
      spi_mosi = eng_mosi;
    end
  end

  assign qm_miso  = grant  ? spi_miso : 1'b0;
  assign eng_miso = map_en ? spi_miso : 1'b0;
endmodule

// File: rtl/flash_boot_arbiter.sv
module flash_boot_arbiter #(
  parameter int WIN_BITS = 25,
  parameter int OFF_W    = WIN_BITS + 1,
  parameter int LEN_W    = 6,
  parameter int ADDR_W   = 24,
  parameter int SETTLE   = 4,
  parameter int REG_DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_addr,
  input  logic              reg_wr_bit,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [OFF_W-1:0]  rd_req_off,
  input  logic [LEN_W-1:0]  rd_req_len,
  output logic              rd_rsp_valid,
  input  logic              rd_rsp_ready,
  output logic [7:0]        rd_rsp_data,
  output logic              rd_rsp_err,
  output logic              rd_rsp_last,
  output logic              qm_grant,
  input  logic              qm_sck,
  input  logic              qm_cs_n,
  input  logic              qm_mosi,
  output logic              qm_miso,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam logic MODE_ADDR = 1'b0;

  logic mode_q, own_q, map_en;
  logic mode_wr, set_q, set_map, start_ok;
  logic eng_busy, eng_sck, eng_cs_n, eng_mosi, eng_miso;

  assign mode_wr  = reg_wr_en && (reg_addr == MODE_ADDR);
  assign set_q    = mode_wr && reg_wr_bit && !eng_busy;
  assign set_map  = mode_wr && !reg_wr_bit;
  assign map_en   = !mode_q && !own_q;
  assign qm_grant = mode_q && own_q;
  assign start_ok = map_en && !mode_wr;

  assign reg_rdata = (reg_addr == MODE_ADDR) ? REG_DW'(mode_q) : REG_DW'(eng_busy);

  flash_own_ctrl #(.SETTLE(SETTLE)) own_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_q   (set_q),
    .set_map (set_map),
    .mode_q  (mode_q),
    .own_q   (own_q)
  );

  flash_map_engine #(
    .WIN_BITS (WIN_BITS),
    .OFF_W    (OFF_W),
    .LEN_W    (LEN_W),
    .ADDR_W   (ADDR_W)
  ) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_off   (rd_req_off),
    .req_len   (rd_req_len),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .rsp_data  (rd_rsp_data),
    .rsp_err   (rd_rsp_err),
    .rsp_last  (rd_rsp_last),
    .busy      (eng_busy),
    .sck       (eng_sck),
    .cs_n      (eng_cs_n),
    .mosi      (eng_mosi),
    .miso      (eng_miso)
  );

  flash_pin_mux mux_i (
    .grant    (qm_grant),
    .map_en   (map_en),
    .eng_sck  (eng_sck),
    .eng_cs_n (eng_cs_n),
    .eng_mosi (eng_mosi),
    .eng_miso (eng_miso),
    .qm_sck   (qm_sck),
    .qm_cs_n  (qm_cs_n),
    .qm_mosi  (qm_mosi),
    .qm_miso  (qm_miso),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso)
  );
endmodule

// File: rtl/flash_boot_arbiter_chk.sv
module flash_boot_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req_ready,
  input logic       rd_rsp_valid,
  input logic       rd_rsp_ready,
  input logic [7:0] rd_rsp_data,
  input logic       rd_rsp_err,
  input logic       rd_rsp_last,
  input logic       qm_grant,
  input logic       spi_sck,
  input logic       spi_cs_n,
  input logic       eng_busy
);
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && !rd_rsp_ready |=> rd_rsp_valid && $stable(rd_rsp_data)
      && $stable(rd_rsp_err) && $stable(rd_rsp_last));

  a_r7_no_accept_granted: assert property (@(posedge clk) disable iff (!rst_n)
    qm_grant |-> !rd_req_ready);

  a_r10_err_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_err && !qm_grant |-> spi_cs_n);

  a_r5_gap_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qm_grant) |-> $past(spi_cs_n) && !$past(spi_sck));

  a_r3_select_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !qm_grant && !spi_cs_n |-> eng_busy);

  a_r8_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !qm_grant && spi_cs_n |-> !spi_sck);

  a_r12_ready_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_ready |-> !eng_busy && !rd_rsp_valid);
endmodule

bind flash_boot_arbiter flash_boot_arbiter_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .rd_rsp_data  (rd_rsp_data),
  .rd_rsp_err   (rd_rsp_err),
  .rd_rsp_last  (rd_rsp_last),
  .qm_grant     (qm_grant),
  .spi_sck      (spi_sck),
  .spi_cs_n     (spi_cs_n),
  .eng_busy     (eng_busy)
);

// File: tb/flash_boot_arbiter_tb_top.sv
`timescale 1ns/1ps
module flash_boot_arbiter_tb_top;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_addr = 1'b1, reg_wr_bit = 1'b0;
  logic [7:0] reg_rdata;
  logic rd_req_valid = 1'b0, rd_req_ready;
  logic [25:0] rd_req_off = '0;
  logic [5:0] rd_req_len = '0;
  logic rd_rsp_valid, rd_rsp_ready = 1'b1, rd_rsp_err, rd_rsp_last;
  logic [7:0] rd_rsp_data;
  logic qm_grant, qm_sck = 1'b0, qm_cs_n = 1'b1, qm_mosi = 1'b0, qm_miso;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic q_miso_drv = 1'b0, slave_miso = 1'b0;

  int checks = 0, errors = 0, cyc = 0, cs_falls = 0, s_bits = 0;
  logic [31:0] s_frame = '0;
  logic [7:0] s_cmd = '0;
  logic [23:0] s_addr = '0;
  logic [9:0] beats[$];

  always #4 clk = ~clk;

  assign spi_miso = qm_grant ? q_miso_drv : slave_miso;

  flash_boot_arbiter #(.SETTLE(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_bit(reg_wr_bit), .reg_rdata(reg_rdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_off(rd_req_off), .rd_req_len(rd_req_len),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err), .rd_rsp_last(rd_rsp_last),
    .qm_grant(qm_grant), .qm_sck(qm_sck), .qm_cs_n(qm_cs_n), .qm_mosi(qm_mosi),
    .qm_miso(qm_miso), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] fdat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Flash model: mode 0, decodes command and address, returns fdat(address)
  always @(negedge spi_cs_n) if (!qm_grant) begin s_bits = 0; cs_falls++; end
  always @(posedge spi_sck) if (!spi_cs_n && !qm_grant) begin
    if (s_bits < 32) s_frame = {s_frame[30:0], spi_mosi};
    s_bits++;
    if (s_bits == 32) begin s_cmd = s_frame[31:24]; s_addr = s_frame[23:0]; end
  end
  always @(negedge spi_sck) if (!spi_cs_n && !qm_grant && s_bits >= 32) begin
    int k;
    logic [7:0] b;
    k = s_bits - 32;
    b = fdat(24'(s_addr + 24'(k / 8)));
    slave_miso = b[7 - (k % 8)];
  end

  // Response collector and per-clock reference checks
  always @(posedge clk) if (rst_n) begin
    if (rd_rsp_valid && rd_rsp_ready) beats.push_back({rd_rsp_err, rd_rsp_last, rd_rsp_data});
    if (qm_grant) begin
      check("R6", "sck follows", spi_sck, qm_sck);
      check("R6", "cs follows", spi_cs_n, qm_cs_n);
      check("R6", "mosi follows", spi_mosi, qm_mosi);
      check("R6", "miso back", qm_miso, q_miso_drv);
    end else if (reg_addr && !reg_wr_en) begin
      check("R3", "busy vs select", reg_rdata[0], !spi_cs_n);
    end
    if (rd_rsp_valid && rd_rsp_err && !qm_grant) check("R10", "no select on error", spi_cs_n, 1);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic reg_write(input logic a, input logic d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_bit = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic read_mode(output logic m);
    reg_addr = 1'b0; #1; m = reg_rdata[0]; reg_addr = 1'b1;
  endtask

  task automatic send_req(input logic [25:0] off, input logic [5:0] len);
    logic acc;
    @(negedge clk);
    rd_req_valid = 1'b1; rd_req_off = off; rd_req_len = len;
    do begin @(posedge clk); acc = rd_req_ready; end while (!acc);
    @(negedge clk);
    rd_req_valid = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    int guard = 0;
    while (beats.size() < n && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic check_beats(input string req, input logic [25:0] off, input int n);
    check(req, "beat count", beats.size(), n);
    for (int i = 0; i < n && i < beats.size(); i++)
      check(req, $sformatf("beat %0d", i), beats[i],
            {1'b0, (i == n - 1), fdat(24'(off[23:0] + 24'(i)))});
    check("R8", "command byte", s_cmd, 8'h03);
    check("R8", "address field", s_addr, off[23:0]);
    beats.delete();
  endtask

  initial begin
    logic m;
    int n, falls0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_mode(m);
    check("R1", "mode", m, 0);
    check("R1", "busy", reg_rdata[0], 0);
    check("R1", "grant", qm_grant, 0);
    check("R1", "cs_n", spi_cs_n, 1);
    check("R1", "rsp_valid", rd_rsp_valid, 0);
    check("R1", "req_ready", rd_req_ready, 1);

    // R8 R9 basic read of four bytes
    send_req(26'h0000123, 6'd3);
    check("R3", "busy after accept", reg_rdata[0], 1);
    wait_beats(4); @(negedge clk);
    check_beats("R9", 26'h0000123, 4);

    // R10 read ending exactly at the window edge is served
    send_req(26'h1FFFFFC, 6'd3);
    wait_beats(4); @(negedge clk);
    check_beats("R10", 26'h1FFFFFC, 4);

    // R10 window violations: one error beat, no chip select
    falls0 = cs_falls;
    send_req(26'h1FFFFFC, 6'd4);
    wait_beats(1); repeat (3) @(negedge clk);
    check("R10", "error beats", beats.size(), 1);
    if (beats.size() > 0) check("R10", "error beat", beats[0][9:8], 2'b11);
    beats.delete();
    send_req(26'h2000000, 6'd0);
    wait_beats(1); repeat (3) @(negedge clk);
    check("R10", "second error", beats.size(), 1);
    if (beats.size() > 0) check("R10", "second error beat", beats[0][9:8], 2'b11);
    check("R10", "no flash traffic", cs_falls, falls0);
    beats.delete();

    // R11 R12 back-pressure
    rd_rsp_ready = 1'b0;
    send_req(26'h00ABCDE, 6'd2);
    repeat (120) @(negedge clk);
    check("R12", "ready low while pending", rd_req_ready, 0);
    for (int i = 0; i < 20; i++) begin
      check("R11", "clock paused", spi_sck, 0);
      check("R11", "select held", spi_cs_n, 0);
      check("R11", "first byte held", rd_rsp_data, fdat(24'hABCDE));
      @(negedge clk);
    end
    rd_rsp_ready = 1'b1;
    wait_beats(3); @(negedge clk);
    check_beats("R11", 26'h00ABCDE, 3);

    // R4 switch refused while busy
    rd_rsp_ready = 1'b0;
    send_req(26'h0000010, 6'd7);
    reg_write(1'b0, 1'b1);
    read_mode(m);
    check("R4", "mode stays 0", m, 0);
    repeat (SETTLE + 3) @(negedge clk);
    check("R4", "no grant", qm_grant, 0);
    rd_rsp_ready = 1'b1;
    wait_beats(8); @(negedge clk);
    check_beats("R4", 26'h0000010, 8);

    // R2 R5 switch to queued master, settle gap with master trying to select
    qm_cs_n = 1'b0; qm_sck = 1'b1;
    reg_write(1'b0, 1'b1);
    n = 0;
    while (!qm_grant && n < 50) begin
      check("R5", "cs high in gap", spi_cs_n, 1);
      check("R5", "sck low in gap", spi_sck, 0);
      n++; @(negedge clk);
    end
    check("R5", "gap to master", n, SETTLE);
    read_mode(m);
    check("R2", "mode reads 1", m, 1);

    // R6 R7 master traffic while a mapped request waits
    rd_req_valid = 1'b1; rd_req_off = 26'h0000040; rd_req_len = 6'd1;
    for (int i = 0; i < 16; i++) begin
      qm_sck = i[0]; qm_mosi = i[1]; q_miso_drv = i[2];
      @(negedge clk);
      check("R7", "request stalled", rd_req_ready, 0);
      check("R7", "no response", rd_rsp_valid, 0);
    end
    qm_cs_n = 1'b1; qm_sck = 1'b0;
    @(negedge clk);

    // R5 R7 return to mapped path; held request served after the gap
    reg_write(1'b0, 1'b0);
    read_mode(m);
    check("R2", "mode reads 0", m, 0);
    n = 0;
    while (!rd_req_ready && n < 50) begin
      check("R5", "cs high returning", spi_cs_n, 1);
      n++; @(negedge clk);
    end
    check("R5", "gap to mapped", n, SETTLE);
    @(negedge clk);
    rd_req_valid = 1'b0;
    wait_beats(2); @(negedge clk);
    check_beats("R7", 26'h0000040, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule